// File: doc/BRIEF.md
# Sync Reference Format Detector

This block watches a horizontal sync, a vertical sync and an optional field sync. All three are sampled on a free-running 27 MHz measurement clock. For each sync it works out which level is the active pulse and times everything from the leading edge of that pulse. It measures the line period in clocks, both as a single value and summed over a block of lines. It also measures the frame period in clocks, the number of lines per frame (single and summed over two frames) and the number of lines per field.

From the line and frame periods the block decides whether the reference is usable. It reports the result as a valid flag, a reference-lost output and a small status word. Downstream timing logic reads the registered measurements to identify the incoming format, and it uses the valid flag to decide whether locking is allowed. A selectable output standard code (62 by default) forces the reference-lost output high whatever the measurements are.

Top module: `ref_fmt_detect`

## Requirements
- R1: Each sync input passes through two flip-flops before edge detection. The polarity of each sync is taken from its shorter level (1 = active-high, 0 = active-low). A new polarity is adopted only after two consecutive periods agree. After reset every polarity is 0.
- R2: `status` carries the overall valid flag in bit 0, the settled line-window flag in bit 1, the settled frame-window flag in bit 2, the horizontal polarity in bit 3, the vertical polarity in bit 4 and the field polarity in bit 5.
- R3: `h_period` is the number of clocks between successive horizontal leading edges. It saturates at HMAX+1 and keeps its last value until another complete period ends.
- R4: `h_period_16` is the sum of 2^H_AVG_LOG2 (16 by default) consecutive line periods, refreshed once per block of lines.
- R5: `v_lines` is the count of horizontal leading edges after one vertical leading edge, up to and including the next. `v_lines_2` is the sum of the last two such counts.
- R6: `f_lines` counts horizontal leading edges per field sync period in the same way. It stays 0 if the field sync never toggles. The field sync has no influence on validity.
- R7: `v_period` is the count of clocks between vertical leading edges, saturating at VMAX+1. `v_period_2` is the sum over a block of two frames.
- R8: A line period within [HMIN, HMAX] and a frame period within [VMIN, VMAX], both inclusive, count as in-window. `ref_valid` is high only when the last two line periods and the last two frame periods were all in-window.
- R9: When a period counter reaches its limit plus one without seeing an edge, the matching window flag is cleared at once, so `ref_valid` drops without waiting for the late edge.
- R10: `ref_lost` is the registered inverse of `ref_valid`, one clock later. It is forced high while `std_sel` equals BYPASS_CODE (62).
- R11: After reset all measurements are 0, `ref_valid` is 0, `status` is 0 and `ref_lost` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, either polarity |
| vsync_in | input | 1 | Vertical sync, either polarity |
| fsync_in | input | 1 | Field sync, optional, either polarity |
| std_sel | input | STDW | Selected output standard code |
| h_period | output | $clog2(HMAX+2) | Clocks per line |
| h_period_16 | output | $clog2(HMAX+2)+H_AVG_LOG2 | Clocks summed over a block of lines |
| v_period | output | $clog2(VMAX+2) | Clocks per frame |
| v_period_2 | output | $clog2(VMAX+2)+1 | Clocks summed over two frames |
| v_lines | output | $clog2(LMAX+1) | Lines per frame |
| v_lines_2 | output | $clog2(LMAX+1)+1 | Lines over the last two frames |
| f_lines | output | $clog2(LMAX+1) | Lines per field period |
| h_pol | output | 1 | Horizontal polarity, 1 = active-high |
| v_pol | output | 1 | Vertical polarity, 1 = active-high |
| ref_valid | output | 1 | Reference within both windows |
| ref_lost | output | 1 | Reference not usable |
| status | output | 6 | Packed flags, see R2 |

## Verification
The bound properties assume nothing about the waveforms on the sync pins. The saturation bounds, the link from a valid flag to in-window periods and the lag and override of the reference-lost output must hold for any input, including glitches and missing pulses. The exact-value checks do depend on the inputs. They need clean periodic syncs whose pulses are shorter than half their period, so the bench keeps every pulse width below that. It also starts vertical and field pulses on a line boundary, which makes line counts exact whatever polarity has been adopted. Between stimulus rows the bench applies reset and then waits eight frames, long enough for polarity to settle and for two-period validity and block sums to refill.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
   localparam int NCH  = 3;
   localparam int CH_H = 0;
   localparam int CH_V = 1;
   localparam int CH_F = 2;
   localparam int STREAK_OK = 2;
endpackage

// File: rtl/rfd_sync_edge.sv
module rfd_sync_edge #(
   parameter int RUNW = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic lead,
   output logic pol
);
   localparam logic [RUNW-1:0] RUN_TOP = '1;

   logic [1:0]      meta;
   logic            prev;
   logic            lvl;
   logic            rise;
   logic            fall;
   logic [RUNW-1:0] run;
   logic [RUNW-1:0] hi_len;
   logic            hi_seen;
   logic            cand;
   logic            cand_seen;
   logic            last_cand;

   assign lvl  = meta[1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
   // high level shorter than low level means an active-high pulse
   assign cand = hi_len < run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta      <= '0;
         prev      <= 1'b0;
         run       <= '0;
         hi_len    <= '0;
         hi_seen   <= 1'b0;
         cand_seen <= 1'b0;
         last_cand <= 1'b0;
         pol       <= 1'b0;
      end else begin
         meta <= {meta[0], sync_in};
         prev <= lvl;
         if (rise || fall)
            run <= RUNW'(1);
         else if (run != RUN_TOP)
            run <= run + RUNW'(1);
         if (fall) begin
            hi_len  <= run;
            hi_seen <= 1'b1;
         end
         if (rise && hi_seen) begin
            last_cand <= cand;
            cand_seen <= 1'b1;
            if (cand_seen && (cand == last_cand))
               pol <= cand;
         end
      end
   end

   assign lead = pol ? rise : fall;
endmodule

// File: rtl/rfd_period.sv
module rfd_period #(
   parameter int MIN_CNT  = 243,
   parameter int MAX_CNT  = 1890,
   parameter int AVG_LOG2 = 4,
   localparam int CW = $clog2(MAX_CNT + 2),
   localparam int AW = CW + AVG_LOG2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lead,
   output logic [CW-1:0] period,
   output logic [AW-1:0] avg,
   output logic          good
);
   import rfd_pkg::*;

   localparam logic [CW-1:0] LO  = CW'(MIN_CNT);
   localparam logic [CW-1:0] HI  = CW'(MAX_CNT);
   localparam logic [CW-1:0] TOP = CW'(MAX_CNT + 1);
   localparam logic [1:0]    OK  = 2'(STREAK_OK);

   logic [CW-1:0] cnt;
   logic          armed;
   logic [1:0]    streak;
   logic          in_win;

   assign in_win = (cnt >= LO) && (cnt <= HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         armed  <= 1'b0;
         streak <= '0;
         period <= '0;
      end else if (lead) begin
         cnt   <= CW'(1);
         armed <= 1'b1;
         if (armed) begin
            period <= cnt;
            if (!in_win)
               streak <= '0;
            else if (streak != OK)
               streak <= streak + 2'd1;
         end
      end else if (cnt != TOP) begin
         cnt <= cnt + CW'(1);
      end else begin
         streak <= '0;
      end
   end

   assign good = (streak == OK);

   generate
      if (AVG_LOG2 > 0) begin : g_avg
         logic [AVG_LOG2-1:0] idx;
         logic [AW-1:0]       acc;
         logic [AW-1:0]       acc_nx;
         logic [AW-1:0]       sum_q;

         assign acc_nx = acc + AW'(cnt);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx   <= '0;
               acc   <= '0;
               sum_q <= '0;
            end else if (lead && armed) begin
               idx <= idx + AVG_LOG2'(1);
               if (&idx) begin
                  sum_q <= acc_nx;
                  acc   <= '0;
               end else begin
                  acc <= acc_nx;
               end
            end
         end
         assign avg = sum_q;
      end else begin : g_plain
         assign avg = period;
      end
   endgenerate
endmodule

// File: rtl/rfd_linecnt.sv
module rfd_linecnt #(
   parameter int LMAX = 2047,
   localparam int LW = $clog2(LMAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          lead,
   output logic [LW-1:0] lines
);
   localparam logic [LW-1:0] TOP = LW'(LMAX);

   logic [LW-1:0] cnt;
   logic [LW-1:0] nxt;
   logic          armed;

   // a tick in the same cycle as the lead closes the current span
   assign nxt = (tick && (cnt != TOP)) ? cnt + LW'(1) : cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         lines <= '0;
      end else if (lead) begin
         cnt   <= '0;
         armed <= 1'b1;
         if (armed)
            lines <= nxt;
      end else begin
         cnt <= nxt;
      end
   end
endmodule

// File: rtl/ref_fmt_detect.sv
module ref_fmt_detect #(
   parameter int HMIN        = 243,
   parameter int HMAX        = 1890,
   parameter int VMIN        = 216000,
   parameter int VMAX        = 1350000,
   parameter int LMAX        = 2047,
   parameter int H_AVG_LOG2  = 4,
   parameter int STDW        = 6,
   parameter int BYPASS_CODE = 62,
   localparam int HCW = $clog2(HMAX + 2),
   localparam int VCW = $clog2(VMAX + 2),
   localparam int LW  = $clog2(LMAX + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      hsync_in,
   input  logic                      vsync_in,
   input  logic                      fsync_in,
   input  logic [STDW-1:0]           std_sel,
   output logic [HCW-1:0]            h_period,
   output logic [HCW+H_AVG_LOG2-1:0] h_period_16,
   output logic [VCW-1:0]            v_period,
   output logic [VCW:0]              v_period_2,
   output logic [LW-1:0]             v_lines,
   output logic [LW:0]               v_lines_2,
   output logic [LW-1:0]             f_lines,
   output logic                      h_pol,
   output logic                      v_pol,
   output logic                      ref_valid,
   output logic                      ref_lost,
   output logic [5:0]                status
);
   import rfd_pkg::*;

   localparam int RUNW = $clog2(VMAX + 2);
   localparam logic [STDW-1:0] BYP = STDW'(BYPASS_CODE);

   generate
      if (HMIN < 1 || HMIN >= HMAX) begin : g_bad_h
         $error("line window limits out of order");
      end
      if (VMIN >= VMAX || HMAX >= VMIN) begin : g_bad_v
         $error("frame window limits out of order");
      end
      if (LMAX < 2 || H_AVG_LOG2 < 1) begin : g_bad_cfg
         $error("line limit or averaging span too small");
      end
   endgenerate

   logic [NCH-1:0] raw;
   logic [NCH-1:0] lead;
   logic [NCH-1:0] pol;
   logic           h_good;
   logic           v_good;
   logic           v_lead_d;
   logic [LW-1:0]  v_last;

   assign raw[CH_H] = hsync_in;
   assign raw[CH_V] = vsync_in;
   assign raw[CH_F] = fsync_in;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         rfd_sync_edge #(.RUNW(RUNW)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (raw[c]),
            .lead    (lead[c]),
            .pol     (pol[c])
         );
      end
   endgenerate

   rfd_period #(.MIN_CNT(HMIN), .MAX_CNT(HMAX), .AVG_LOG2(H_AVG_LOG2)) u_hper (
      .clk    (clk),
      .rst_n  (rst_n),
      .lead   (lead[CH_H]),
      .period (h_period),
      .avg    (h_period_16),
      .good   (h_good)
   );

   rfd_period #(.MIN_CNT(VMIN), .MAX_CNT(VMAX), .AVG_LOG2(1)) u_vper (
      .clk    (clk),
      .rst_n  (rst_n),
      .lead   (lead[CH_V]),
      .period (v_period),
      .avg    (v_period_2),
      .good   (v_good)
   );

   rfd_linecnt #(.LMAX(LMAX)) u_vlines (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (lead[CH_H]),
      .lead  (lead[CH_V]),
      .lines (v_lines)
   );

   rfd_linecnt #(.LMAX(LMAX)) u_flines (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (lead[CH_H]),
      .lead  (lead[CH_F]),
      .lines (f_lines)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_lead_d  <= 1'b0;
         v_last    <= '0;
         v_lines_2 <= '0;
         ref_lost  <= 1'b1;
      end else begin
         v_lead_d <= lead[CH_V];
         if (v_lead_d) begin
            v_lines_2 <= {1'b0, v_lines} + {1'b0, v_last};
            v_last    <= v_lines;
         end
         ref_lost <= !(h_good && v_good) || (std_sel == BYP);
      end
   end

   assign ref_valid = h_good && v_good;
   assign h_pol     = pol[CH_H];
   assign v_pol     = pol[CH_V];
   assign status    = {pol[CH_F], pol[CH_V], pol[CH_H], v_good, h_good, ref_valid};
endmodule

// File: rtl/rfd_chk.sv
module rfd_chk #(
   parameter int HMIN        = 243,
   parameter int HMAX        = 1890,
   parameter int VMIN        = 216000,
   parameter int VMAX        = 1350000,
   parameter int H_AVG_LOG2  = 4,
   parameter int STDW        = 6,
   parameter int BYPASS_CODE = 62,
   localparam int HCW = $clog2(HMAX + 2),
   localparam int VCW = $clog2(VMAX + 2)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [STDW-1:0]           std_sel,
   input logic [HCW-1:0]            h_period,
   input logic [HCW+H_AVG_LOG2-1:0] h_period_16,
   input logic [VCW-1:0]            v_period,
   input logic                      ref_valid,
   input logic                      ref_lost
);
   localparam logic [HCW-1:0] H_LO  = HCW'(HMIN);
   localparam logic [HCW-1:0] H_HI  = HCW'(HMAX);
   localparam logic [HCW-1:0] H_TOP = HCW'(HMAX + 1);
   localparam logic [VCW-1:0] V_LO  = VCW'(VMIN);
   localparam logic [VCW-1:0] V_HI  = VCW'(VMAX);
   localparam logic [HCW+H_AVG_LOG2-1:0] H16_TOP = (HCW + H_AVG_LOG2)'((HMAX + 1) << H_AVG_LOG2);
   localparam logic [STDW-1:0] BYP = STDW'(BYPASS_CODE);

   assert_hsat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      h_period <= H_TOP);

   assert_havg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      h_period_16 <= H16_TOP);

   assert_valid_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |-> (h_period >= H_LO && h_period <= H_HI && v_period >= V_LO && v_period <= V_HI));

   assert_lost_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_lost |-> ($past(ref_valid) && ($past(std_sel) != BYP)));

   assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (std_sel == BYP) |=> ref_lost);
endmodule

bind ref_fmt_detect rfd_chk #(
   .HMIN(HMIN), .HMAX(HMAX), .VMIN(VMIN), .VMAX(VMAX),
   .H_AVG_LOG2(H_AVG_LOG2), .STDW(STDW), .BYPASS_CODE(BYPASS_CODE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .std_sel     (std_sel),
   .h_period    (h_period),
   .h_period_16 (h_period_16),
   .v_period    (v_period),
   .ref_valid   (ref_valid),
   .ref_lost    (ref_lost)
);

// File: tb/sim_ref_fmt_detect.sv
module sim_ref_fmt_detect;
   localparam int HMIN = 20;
   localparam int HMAX = 300;
   localparam int VMIN = 500;
   localparam int VMAX = 3000;
   localparam int LMAX = 255;

   typedef struct packed {
      int hp; int hw; int hpol; int vl; int vpol; int fl; int fen; int std;
   } vec_t;

   // line clocks, pulse width, H polarity, lines/frame, V polarity, lines/field, field on, std code
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{50,  4, 0, 20, 0, 10, 0, 0},
      '{64,  6, 1, 25, 1, 12, 1, 0},
      '{150, 10, 1, 12, 0, 6, 1, 0},
      '{20,  2, 0, 25, 1, 5, 1, 0},
      '{300, 20, 1, 10, 0, 5, 1, 0},
      '{301, 20, 0, 8, 1, 4, 1, 0},
      '{19,  2, 1, 30, 0, 10, 1, 0},
      '{100, 8, 0, 31, 0, 10, 1, 0},
      '{50,  4, 1, 9, 1, 3, 1, 0},
      '{50,  4, 0, 20, 1, 10, 1, 62}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_in = 1'b1;
   logic vsync_in = 1'b1;
   logic fsync_in = 1'b0;
   logic [5:0] std_sel = '0;
   logic [8:0] h_period;
   logic [12:0] h_period_16;
   logic [11:0] v_period;
   logic [12:0] v_period_2;
   logic [7:0] v_lines;
   logic [8:0] v_lines_2;
   logic [7:0] f_lines;
   logic h_pol, v_pol, ref_valid, ref_lost;
   logic [5:0] status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit gen_on = 0;
   vec_t cur = VECS[0];
   int hc = 0, ln = 0, fc = 0;

   always #2 clk = ~clk;

   ref_fmt_detect #(.HMIN(HMIN), .HMAX(HMAX), .VMIN(VMIN), .VMAX(VMAX), .LMAX(LMAX)) u0 (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in), .fsync_in(fsync_in),
      .std_sel(std_sel), .h_period(h_period), .h_period_16(h_period_16), .v_period(v_period),
      .v_period_2(v_period_2), .v_lines(v_lines), .v_lines_2(v_lines_2), .f_lines(f_lines),
      .h_pol(h_pol), .v_pol(v_pol), .ref_valid(ref_valid), .ref_lost(ref_lost), .status(status)
   );

   // sync generator: V and F pulses start on the same cycle as an H pulse
   always @(negedge clk) begin
      if (!gen_on) begin
         hc = 0; ln = 0; fc = 0;
      end else if (hc == cur.hp - 1) begin
         hc = 0;
         ln = (ln == cur.vl - 1) ? 0 : ln + 1;
         fc = (fc == cur.fl - 1) ? 0 : fc + 1;
      end else begin
         hc = hc + 1;
      end
      hsync_in = ((hc < cur.hw) == (cur.hpol != 0));
      vsync_in = ((ln < 3) == (cur.vpol != 0));
      fsync_in = (cur.fen != 0) ? ((fc < 1) == (cur.vpol != 0)) : 1'b0;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic run_row(input vec_t v);
      rst_n = 1'b0;
      gen_on = 0;
      cur = v;
      std_sel = 6'(v.std);
      repeat (4) @(negedge clk);
      gen_on = 1;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (8 * v.hp * v.vl + 20 * v.hp) @(negedge clk);
   endtask

   initial begin
      repeat (198000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R11 actual=running expected=finished");
         report();
      end
   end

   initial begin
      // R11: reset state
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 h_period after reset", int'(h_period), 0);
      chk("R11 v_lines after reset", int'(v_lines), 0);
      chk("R11 ref_valid after reset", int'(ref_valid), 0);
      chk("R11 ref_lost after reset", int'(ref_lost), 1);
      chk("R11 status after reset", int'(status), 0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         int hin, vin, vclk, hpm, vpm, ok, fpol;
         v = VECS[i];
         run_row(v);
         vclk = v.hp * v.vl;
         hin  = (v.hp >= HMIN && v.hp <= HMAX) ? 1 : 0;
         vin  = (vclk >= VMIN && vclk <= VMAX) ? 1 : 0;
         hpm  = (v.hp > HMAX) ? HMAX + 1 : v.hp;
         vpm  = (vclk > VMAX) ? VMAX + 1 : vclk;
         ok   = hin & vin;
         fpol = (v.fen != 0) ? v.vpol : 0;
         chk("R3 h_period", int'(h_period), hpm);
         chk("R4 h_period_16", int'(h_period_16), 16 * hpm);
         chk("R7 v_period", int'(v_period), vpm);
         chk("R7 v_period_2", int'(v_period_2), 2 * vpm);
         chk("R5 v_lines", int'(v_lines), v.vl);
         chk("R5 v_lines_2", int'(v_lines_2), 2 * v.vl);
         chk("R6 f_lines", int'(f_lines), (v.fen != 0) ? v.fl : 0);
         chk("R1 h_pol", int'(h_pol), v.hpol);
         chk("R1 v_pol", int'(v_pol), v.vpol);
         chk("R8 ref_valid", int'(ref_valid), ok);
         chk("R10 ref_lost", int'(ref_lost), (ok == 0 || v.std == 62) ? 1 : 0);
         chk("R2 status", int'(status), (fpol << 5) | (v.vpol << 4) | (v.hpol << 3) | (vin << 2) | (hin << 1) | ok);
      end

      // R10: override code takes effect one clock later, and releases one clock later
      run_row(VECS[0]);
      chk("R6 valid without field sync", int'(ref_valid), 1);
      chk("R10 ref_lost low when valid", int'(ref_lost), 0);
      std_sel = 6'd62;
      @(negedge clk);
      chk("R10 ref_lost forced by code", int'(ref_lost), 1);
      std_sel = 6'd0;
      @(negedge clk);
      chk("R10 ref_lost released", int'(ref_lost), 0);

      // R9: stopping the syncs drops validity once the line counter overflows
      gen_on = 0;
      repeat (HMAX + 20) @(negedge clk);
      chk("R9 ref_valid after sync stops", int'(ref_valid), 0);
      chk("R9 ref_lost after sync stops", int'(ref_lost), 1);
      chk("R9 line flag after sync stops", int'(status[1]), 0);
      chk("R3 h_period holds last value", int'(h_period), VECS[0].hp);

      done = 1;
      report();
   end
endmodule